// File: doc/BRIEF.md
# Port Status LED Flash-Code Driver

This block turns a three-bit port status code into the enable for an open-drain LED pull-down. A port with no device, an open line, a short termination or a reserved code leaves the LED dark. A powered port holds the LED lit. Three fault codes light it in bursts of one, two or five flashes, and each burst repeats on a fixed frame. All timing is counted in periods of an external one-millisecond strobe, so the block runs from any system clock.

When the LED supply is derived from the high-voltage rail, a steady pull-down would overheat the series components. A select input therefore chops every lit interval into a pulse train. The period and the pulse width are given in system clocks. Each lit interval starts a fresh chopping period. When the select is low, the pin is pulled down for the whole lit interval.

The sequencer is a five-state machine. `SEQ_DARK` and `SEQ_STEADY` hold the LED off or on. `SEQ_FLASH`, `SEQ_GAP` and `SEQ_REST` walk through one frame. The named transitions are:
- **restart**: from any state, when the code input differs from the stored code, to the new code's entry state.
- **flash-end**: `SEQ_FLASH` to `SEQ_GAP`.
- **next-flash**: `SEQ_GAP` to `SEQ_FLASH`.
- **burst-done**: `SEQ_GAP` to `SEQ_REST`.
- **wrap**: `SEQ_REST` or the last `SEQ_GAP` to `SEQ_FLASH`, when the frame ends.

Top module: `led_status_drv`

## Requirements
- R1: From reset, and afterwards while the code is 0, the output `led_pull_o` is 0.
- R2: Codes 0 (no device), 2 (open), 3 (short termination) and 7 (reserved) keep the output at 0. The output is 0 within two clocks of such a code appearing, even in the middle of a flash.
- R3: Code 1 (powered) keeps the LED lit without interruption.
- R4: Code 4 gives one flash per frame, code 5 gives two and code 6 gives five.
- R5: Each flash stays lit for FLASH_MS strobes (75). Flash k of a burst begins k·PITCH_MS strobes (300) after the frame start.
- R6: A frame lasts the larger of FRAME_MS (1200) and burst length × PITCH_MS strobes. The next frame's first flash begins right after that.
- R7: Any change of the code input restarts the frame at the new code's first flash. No flash or gap of the old burst carries over.
- R8: With `int_supply_i` = 0, the output is 1 on every clock of a lit interval.
- R9: With `int_supply_i` = 1, a lit interval pulls down for PWM_LOW clocks out of every PWM_PERIOD clocks, and never for more than PWM_LOW clocks in a row.
- R10: Every lit interval starts with a full pull-down pulse at the beginning of a new chopping period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ms_tick_i | input | 1 | One-clock strobe once per millisecond |
| status_i | input | 3 | Port status code (encoding in R2 to R4) |
| int_supply_i | input | 1 | 1 = chop lit intervals (internal LED supply), 0 = solid drive |
| led_pull_o | output | 1 | Pull-down enable for the open-drain LED pin |

## Verification
A code change reaches the pin two clock edges later: one edge loads the sequencer state and one loads the output register. A flash boundary appears one edge after the clock edge that consumes the strobe. A chopping pulse appears one edge after its counter value. The bench issues one strobe every eight clocks. It changes inputs two clocks into a millisecond and samples six clocks into it, so every level it checks has settled. Chopping is judged by counting pull-down clocks over whole-millisecond windows whose length is a multiple of the chop period, so the count does not depend on where a lit interval started inside a millisecond.

// File: rtl/led_code_pkg.sv
package led_code_pkg;

    localparam int CODE_W    = 3;
    localparam int BURST_MAX = 5;

    typedef enum logic [CODE_W-1:0] {
        CODE_IDLE     = 3'd0,
        CODE_POWERED  = 3'd1,
        CODE_OPEN     = 3'd2,
        CODE_SHORT    = 3'd3,
        CODE_SIG_LOW  = 3'd4,
        CODE_SIG_HIGH = 3'd5,
        CODE_OVERLOAD = 3'd6,
        CODE_SPARE    = 3'd7
    } port_code_e;

    typedef enum logic [2:0] {
        SEQ_DARK   = 3'd0,
        SEQ_STEADY = 3'd1,
        SEQ_FLASH  = 3'd2,
        SEQ_GAP    = 3'd3,
        SEQ_REST   = 3'd4
    } seq_state_e;

    // Flashes per frame for a code; zero for codes that never flash.
    function automatic int burst_len(logic [CODE_W-1:0] c);
        case (c)
            CODE_SIG_LOW:  return 1;
            CODE_SIG_HIGH: return 2;
            CODE_OVERLOAD: return BURST_MAX;
            default:       return 0;
        endcase
    endfunction

    // Frame length in strobes: never shorter than the burst itself.
    function automatic int frame_ticks(int n, int pitch, int frame);
        return (n * pitch > frame) ? n * pitch : frame;
    endfunction

    function automatic seq_state_e entry_state(logic [CODE_W-1:0] c);
        if (c == CODE_POWERED)
            return SEQ_STEADY;
        else if (burst_len(c) > 0)
            return SEQ_FLASH;
        else
            return SEQ_DARK;
    endfunction

    function automatic logic is_dark(logic [CODE_W-1:0] c);
        return entry_state(c) == SEQ_DARK;
    endfunction

endpackage

// File: rtl/led_frame_seq.sv
module led_frame_seq
    import led_code_pkg::*;
#(
    parameter int FLASH_MS = 75,
    parameter int PITCH_MS = 300,
    parameter int FRAME_MS = 1200
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ms_tick_i,
    input  logic [CODE_W-1:0] status_i,
    output logic              lamp_on_o
);

    localparam int LONGEST = frame_ticks(BURST_MAX, PITCH_MS, FRAME_MS);
    localparam int MSW     = $clog2(LONGEST + 1);
    localparam int SLW     = $clog2(PITCH_MS + 1);
    localparam int IDXW    = $clog2(BURST_MAX + 1);

    seq_state_e        state_q, state_d;
    logic [CODE_W-1:0] code_q, code_d;
    logic [MSW-1:0]    frame_q, frame_d;
    logic [SLW-1:0]    slot_q, slot_d;
    logic [IDXW-1:0]   idx_q, idx_d;

    logic code_change;
    int   burst;
    int   flen;

    always_comb begin
        burst       = burst_len(code_q);
        flen        = frame_ticks(burst, PITCH_MS, FRAME_MS);
        code_change = (status_i != code_q);
    end

    // Next-state and counter logic.
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        idx_d   = idx_q;
        frame_d = frame_q;
        slot_d  = slot_q;

        if (ms_tick_i && (state_q == SEQ_FLASH || state_q == SEQ_GAP || state_q == SEQ_REST))
            frame_d = frame_q + 1'b1;
        if (ms_tick_i && (state_q == SEQ_FLASH || state_q == SEQ_GAP))
            slot_d = slot_q + 1'b1;

        if (code_change) begin
            // restart
            code_d  = status_i;
            frame_d = '0;
            slot_d  = '0;
            idx_d   = '0;
            state_d = entry_state(status_i);
        end else begin
            unique case (state_q)
                SEQ_DARK, SEQ_STEADY: begin
                    frame_d = '0;
                    slot_d  = '0;
                end
                SEQ_FLASH: begin
                    // flash-end
                    if (ms_tick_i && slot_q == SLW'(FLASH_MS - 1))
                        state_d = SEQ_GAP;
                end
                SEQ_GAP: begin
                    if (ms_tick_i && slot_q == SLW'(PITCH_MS - 1)) begin
                        slot_d = '0;
                        if (int'(idx_q) + 1 < burst) begin
                            // next-flash
                            idx_d   = idx_q + 1'b1;
                            state_d = SEQ_FLASH;
                        end else if (int'(frame_q) == flen - 1) begin
                            // wrap straight from the last gap
                            frame_d = '0;
                            idx_d   = '0;
                            state_d = SEQ_FLASH;
                        end else begin
                            // burst-done
                            idx_d   = '0;
                            state_d = SEQ_REST;
                        end
                    end
                end
                SEQ_REST: begin
                    slot_d = '0;
                    if (ms_tick_i && int'(frame_q) == flen - 1) begin
                        // wrap
                        frame_d = '0;
                        idx_d   = '0;
                        state_d = SEQ_FLASH;
                    end
                end
                default: state_d = SEQ_DARK;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= SEQ_DARK;
            code_q  <= CODE_IDLE;
            frame_q <= '0;
            slot_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
            frame_q <= frame_d;
            slot_q  <= slot_d;
            idx_q   <= idx_d;
        end
    end

    // Outputs.
    always_comb begin
        lamp_on_o = (state_q == SEQ_STEADY) || (state_q == SEQ_FLASH);
    end

    AST_FRAME_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SEQ_FLASH || state_q == SEQ_GAP || state_q == SEQ_REST) |-> int'(frame_q) < flen); // R6
    AST_BURST_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SEQ_FLASH || state_q == SEQ_GAP) |-> int'(idx_q) < burst); // R4
    AST_FLASH_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SEQ_FLASH) |-> int'(slot_q) < FLASH_MS); // R5
    AST_RESTART_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (code_q != $past(code_q)) |-> (frame_q == '0 && slot_q == '0 && idx_q == '0)); // R7

endmodule

// File: rtl/led_pwm_chop.sv
module led_pwm_chop #(
    parameter int PWM_PERIOD = 4464,
    parameter int PWM_LOW    = 275
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lamp_on_i,
    input  logic int_supply_i,
    output logic pull_o
);

    localparam int CW = (PWM_PERIOD > 1) ? $clog2(PWM_PERIOD) : 1;

    logic gate;
    logic pull_q;

    generate
        if (PWM_PERIOD < 2 || PWM_LOW >= PWM_PERIOD) begin : g_solid
            always_comb gate = 1'b1;
        end else begin : g_chop
            logic [CW-1:0] cnt_q;
            logic [CW:0]   run_q;
            logic          mode_q;

            // Period counter held at zero while dark, so every lit interval starts a period.
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)
                    cnt_q <= '0;
                else if (!lamp_on_i)
                    cnt_q <= '0;
                else if (cnt_q == CW'(PWM_PERIOD - 1))
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end

            always_comb gate = (cnt_q < CW'(PWM_LOW));

            // Run-length counter for the pulse-width check.
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    mode_q <= 1'b0;
                    run_q  <= '0;
                end else begin
                    mode_q <= int_supply_i && lamp_on_i;
                    run_q  <= (pull_q && mode_q) ? run_q + 1'b1 : '0;
                end
            end

            AST_PERIOD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (lamp_on_i && !$past(lamp_on_i)) |-> cnt_q == '0); // R10
            AST_LOW_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (pull_q && mode_q) |-> int'(run_q) < PWM_LOW); // R9
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            pull_q <= 1'b0;
        else
            pull_q <= lamp_on_i && (!int_supply_i || gate);
    end

    assign pull_o = pull_q;

endmodule

// File: rtl/led_status_drv.sv
module led_status_drv
    import led_code_pkg::*;
#(
    parameter int FLASH_MS   = 75,
    parameter int PITCH_MS   = 300,
    parameter int FRAME_MS   = 1200,
    parameter int PWM_PERIOD = 4464,
    parameter int PWM_LOW    = 275
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ms_tick_i,
    input  logic [CODE_W-1:0] status_i,
    input  logic              int_supply_i,
    output logic              led_pull_o
);

    logic lamp_on;

    led_frame_seq #(
        .FLASH_MS (FLASH_MS),
        .PITCH_MS (PITCH_MS),
        .FRAME_MS (FRAME_MS)
    ) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ms_tick_i (ms_tick_i),
        .status_i  (status_i),
        .lamp_on_o (lamp_on)
    );

    led_pwm_chop #(
        .PWM_PERIOD (PWM_PERIOD),
        .PWM_LOW    (PWM_LOW)
    ) u_chop (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .lamp_on_i    (lamp_on),
        .int_supply_i (int_supply_i),
        .pull_o       (led_pull_o)
    );

    AST_EXT_SOLID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(lamp_on) && !$past(int_supply_i)) |-> led_pull_o); // R8
    AST_DARK_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_dark($past(status_i, 2)) |-> !led_pull_o); // R2

endmodule

// File: tb/led_status_drv_tb.sv
module led_status_drv_tb;

    localparam int TICK_CLKS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       int_sel = 1'b0;
    logic [2:0] status = 3'd0;
    logic       led;

    always #4 clk = ~clk;

    led_status_drv #(
        .PWM_PERIOD (16),
        .PWM_LOW    (2)
    ) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .ms_tick_i    (ms_tick),
        .status_i     (status),
        .int_supply_i (int_sel),
        .led_pull_o   (led)
    );

    int checks = 0;
    int fails = 0;
    int ms_now = 0;
    int pull_cnt = 0;
    int run_len = 0;
    int max_run = 0;
    int snap [2048];
    bit finished = 0;
    event ph2_ev, ph6_ev;

    typedef struct {
        int    ms;
        int    span;
        int    val;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (ms %0d)", tag, act, exp, ms_now);
        end
    endtask

    // Strobe generator and pin sampler.
    initial begin
        int phase;
        phase = 0;
        forever begin
            @(negedge clk);
            if (led) begin
                pull_cnt++;
                run_len++;
                if (run_len > max_run) max_run = run_len;
            end else begin
                run_len = 0;
            end
            phase = (phase == TICK_CLKS - 1) ? 0 : phase + 1;
            ms_tick = (phase == 0);
            if (phase == 1) ms_now++;
            if (phase == 2) -> ph2_ev;
            if (phase == 6) begin
                snap[ms_now % 2048] = pull_cnt;
                -> ph6_ev;
            end
        end
    end

    // Monitor: pops expectations when their millisecond is reached.
    initial begin
        forever begin
            @(ph6_ev);
            while (sb_q.size() > 0 && sb_q[0].ms <= ms_now) begin
                exp_t it;
                it = sb_q.pop_front();
                if (it.ms < ms_now)
                    chk({it.tag, " missed sample"}, 0, 1);
                else if (it.span == 0)
                    chk(it.tag, int'(led), it.val);
                else
                    chk(it.tag, snap[it.ms % 2048] - snap[(it.ms - it.span) % 2048], it.val);
            end
        end
    end

    task automatic apply(int code, output int m);
        @(ph2_ev);
        status = 3'(code);
        m = ms_now;
    endtask

    task automatic lvl(int ms, int v, string tag);
        exp_t e;
        e = '{ms, 0, v, tag};
        sb_q.push_back(e);
    endtask

    task automatic cnt(int ms_end, int span, int v, string tag);
        exp_t e;
        e = '{ms_end, span, v, tag};
        sb_q.push_back(e);
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(ph6_ev);
    endtask

    initial begin
        int m;
        repeat (5) @(negedge clk);
        chk("R1 in reset", int'(led), 0);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset
        @(ph2_ev);
        m = ms_now;
        lvl(m + 5, 0, "R1 idle");
        cnt(m + 40, 30, 0, "R1 idle window");
        drain();

        // R3 / R8: powered, solid drive
        apply(1, m);
        lvl(m + 3, 1, "R3 powered");
        cnt(m + 45, 40, 320, "R8 solid window");
        lvl(m + 50, 1, "R3 powered");
        drain();

        // R4 / R5 / R6: single flash frame
        apply(4, m);
        lvl(m + 10, 1, "R4 flash 1");
        lvl(m + 74, 1, "R5 flash width");
        lvl(m + 75, 0, "R5 flash end");
        lvl(m + 310, 0, "R4 no 2nd flash");
        lvl(m + 610, 0, "R4 no 3rd flash");
        lvl(m + 1199, 0, "R6 frame rest");
        lvl(m + 1200, 1, "R6 frame wrap");
        lvl(m + 1274, 1, "R5 flash width");
        lvl(m + 1275, 0, "R5 flash end");
        drain();

        // R4 / R5: two flashes, interrupted in the second one
        apply(5, m);
        lvl(m + 10, 1, "R4 flash 1");
        lvl(m + 80, 0, "R5 gap");
        lvl(m + 290, 0, "R5 gap");
        lvl(m + 302, 1, "R5 pitch");
        drain();

        // R7 / R4 / R6: restart into five-flash burst
        apply(6, m);
        lvl(m + 3, 1, "R7 restart lit");
        lvl(m + 74, 1, "R7 full first flash");
        lvl(m + 76, 0, "R7 first gap");
        lvl(m + 310, 1, "R4 flash 2");
        lvl(m + 610, 1, "R4 flash 3");
        lvl(m + 910, 1, "R4 flash 4");
        lvl(m + 1210, 1, "R4 flash 5");
        lvl(m + 1290, 0, "R6 after burst");
        lvl(m + 1499, 0, "R6 stretched frame");
        lvl(m + 1500, 1, "R6 stretched wrap");
        drain();

        // R2: dark codes, first one mid-flash
        apply(2, m);
        lvl(m + 1, 0, "R2 open");
        lvl(m + 20, 0, "R2 open");
        drain();
        apply(3, m);
        lvl(m + 1, 0, "R2 short");
        lvl(m + 20, 0, "R2 short");
        drain();
        apply(7, m);
        lvl(m + 1, 0, "R2 spare");
        lvl(m + 20, 0, "R2 spare");
        drain();

        // R9 / R10: chopped two-flash burst
        @(ph2_ev);
        int_sel = 1'b1;
        max_run = 0;
        apply(5, m);
        cnt(m + 65, 60, 60, "R9 chop count");
        cnt(m + 290, 190, 0, "R9 gap dark");
        cnt(m + 300, 1, 2, "R10 period start");
        cnt(m + 365, 60, 60, "R9 chop count");
        drain();
        chk("R9 max pulse run", max_run, 2);

        // R9: chopped steady
        max_run = 0;
        apply(1, m);
        cnt(m + 90, 80, 80, "R9 steady chop");
        drain();
        chk("R9 max pulse run", max_run, 2);

        // R8: back to solid drive without a code change
        @(ph2_ev);
        int_sel = 1'b0;
        m = ms_now;
        cnt(m + 45, 40, 320, "R8 solid again");
        lvl(m + 46, 1, "R8 solid again");
        drain();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog (all requirements) actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule